// File: doc/BRIEF.md
# Event Timer with Free-Running Timestamp

This peripheral pairs two counters behind a small synchronous register bus. A free-running up-counter provides a timestamp that software reads as a full word. Beside it, a down-counter serves as an event timer: software loads a count, arms the timer, and gets an interrupt when the count runs out. Both counters advance only on cycles where the `tick_en` strobe is high. The strobe comes from a 1 MHz timebase outside the block.

A single control/status byte does two jobs. It arms or stops the countdown and selects how the countdown ends. It also carries a sticky terminal-count flag, which software clears by writing a one to bit 7. A typical driver first writes 0x80, which clears the flag and stops counting. It then loads the count register and writes 0x81, which arms a one-shot countdown from the value just loaded. Setting both the period bit and the reload bit makes the timer restart from the last loaded value each time it expires.

Register offsets: count at 0x00, timestamp at 0x08, control/status at 0x14. The control/status byte sits in data bits [7:0] of its word.

Top module: `evt_tmr_top`

## Requirements
- R1: After reset, the count register, the timestamp and the control/status byte all read 0, and `irq` is low.
- R2: The timestamp (TS_W bits, 32 by default) increases by one on every cycle with `tick_en` high and wraps from all-ones to 0. It does not change without a tick. Writes to offset 0x08 or to the control byte have no effect on it.
- R3: A write to offset 0x00 loads each byte of the count whose `bus_be` bit is set, both in the live count and in the reload value. Bytes whose enable is clear keep their value.
- R4: While enable (control bit 0) is set, a tick with a count above 1 lowers the count by exactly one. Without a tick, or with enable clear, the count holds.
- R5: A tick with enable set and a count of 1 or 0 is a terminal count. It sets the flag (bit 7), leaves the count at 0 and clears enable, unless both period (bit 1) and reload (bit 2) are set.
- R6: When period and reload are both set, a terminal count reloads the last written count value, keeps enable set and still sets the flag.
- R7: Writing the control byte with bit 7 set clears the flag. Writing it with bit 7 clear leaves the flag as it was. Writing 0x80 also stops the countdown.
- R8: If a terminal count falls in the same cycle as a write that clears the flag, the flag ends up set.
- R9: `irq` is high exactly while the flag is set.
- R10: Reads of any offset other than 0x00, 0x08 and 0x14 return 0, and writes to them change nothing. Control bits 3 to 6 and bits 31:8 of that word read as 0.
- R11: Writing 0x81 while the flag is pending clears it and arms the countdown. The next tick then counts down from the loaded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle timebase strobe that advances both counters |
| bus_addr | input | ADDR_W | Byte offset of the register being accessed |
| bus_we | input | 1 | Write strobe |
| bus_be | input | DATA_W/8 | Byte enables for a write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt, high while the terminal-count flag is set |

## Verification
Two events can land in the same cycle: the countdown reaching its terminal tick, and a software write to the control byte that clears the flag. The bench provokes this by loading a count of 1, arming the timer, and then writing 0x80 in the very cycle that `tick_en` is high. It then requires the flag and `irq` to be set while enable reads as cleared. A behavioural model runs alongside the design and compares every register read and `irq` on every clock. This catches any cycle in which the design resolves the collision, or a load-versus-tick overlap, differently.

// File: rtl/evt_tmr_pkg.sv
// Shared constants for the event timer: register offsets, control-bit
// positions and the control/status record. Assumes byte addressing.
package evt_tmr_pkg;
    localparam int unsigned OFS_COUNT  = 'h00;
    localparam int unsigned OFS_TSTAMP = 'h08;
    localparam int unsigned OFS_CTRL   = 'h14;

    localparam int unsigned CB_EN  = 0;
    localparam int unsigned CB_PER = 1;
    localparam int unsigned CB_RLD = 2;
    localparam int unsigned CB_TC  = 7;

    typedef struct packed {
        logic tc;
        logic rld;
        logic per;
        logic en;
    } ctrl_t;
endpackage

// File: rtl/evt_tmr_tstamp.sv
// Free-running timestamp. Advances by one on each tick and wraps
// naturally at TS_W bits. Assumes tick is a one-cycle strobe.
module evt_tmr_tstamp #(
    parameter int unsigned TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    output logic [TS_W-1:0] ts_q
);
    // Count ticks, wrapping modulo 2**TS_W.
    always_ff @(posedge clk) begin
        if (!rst_n)    ts_q <= '0;
        else if (tick) ts_q <= ts_q + 1'b1;
    end
endmodule

// File: rtl/evt_tmr_cdown.sv
// Countdown core. Holds the live count and a reload copy, both loaded
// byte-wise from the bus. Decrements on ticks while running. A count
// of 1 or 0 at a running tick is a terminal count. Assumes CNT_W is a
// multiple of 8 and no wider than DATA_W.
module evt_tmr_cdown #(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned BE_W  = DATA_W / 8,
    localparam int unsigned NB    = CNT_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              auto_rld,
    input  logic              ld_we,
    input  logic [BE_W-1:0]   ld_be,
    input  logic [DATA_W-1:0] ld_data,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              tc_pulse
);
    logic [CNT_W-1:0] rld_q;
    logic [CNT_W-1:0] cnt_mrg;
    logic [CNT_W-1:0] rld_mrg;

    // Merge enabled bytes of the write data over the held values.
    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign cnt_mrg[b*8 +: 8] = ld_be[b] ? ld_data[b*8 +: 8] : cnt_q[b*8 +: 8];
        assign rld_mrg[b*8 +: 8] = ld_be[b] ? ld_data[b*8 +: 8] : rld_q[b*8 +: 8];
    end

    // Terminal count: running tick with the count at one or zero.
    assign tc_pulse = run && tick && (cnt_q <= CNT_W'(1));

    // A bus load wins over a tick; otherwise decrement or end the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rld_q <= '0;
        end else if (ld_we) begin
            cnt_q <= cnt_mrg;
            rld_q <= rld_mrg;
        end else if (run && tick) begin
            if (tc_pulse) cnt_q <= auto_rld ? rld_q : '0;
            else          cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/evt_tmr_csr.sv
// Control/status byte. A write sets the mode bits; bit 7 of a write
// clears the sticky flag, and a terminal count sets it (set wins).
// One-shot mode drops enable at terminal count unless a write lands
// in that same cycle.
module evt_tmr_csr
    import evt_tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic [7:0] wr_byte,
    input  logic       tc_pulse,
    output ctrl_t      ctrl_q
);
    logic unused_bits;
    assign unused_bits = ^wr_byte[6:3];

    // Update the mode bits and the sticky terminal-count flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_stb) begin
                ctrl_q.en  <= wr_byte[CB_EN];
                ctrl_q.per <= wr_byte[CB_PER];
                ctrl_q.rld <= wr_byte[CB_RLD];
            end else if (tc_pulse && !(ctrl_q.per && ctrl_q.rld)) begin
                ctrl_q.en  <= 1'b0;
            end
            ctrl_q.tc <= (ctrl_q.tc && !(wr_stb && wr_byte[CB_TC])) || tc_pulse;
        end
    end
endmodule

// File: rtl/evt_tmr_top.sv
// Register-mapped event timer: byte-enabled count register, read-only
// timestamp and a control/status byte, decoded on a byte-offset bus.
// Reads are combinational from bus_addr. Unmapped offsets read 0 and
// ignore writes.
module evt_tmr_top
    import evt_tmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned TS_W   = 32,
    localparam int unsigned BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic             hit_cnt, hit_ts, hit_ctrl;
    logic             cnt_we, ctrl_we;
    logic [7:0]       ctrl_wbyte;
    logic [CNT_W-1:0] cnt_q;
    logic [TS_W-1:0]  ts_q;
    logic             tc_pulse;
    ctrl_t            ctrl_q;
    logic             en_q, per_q, rld_q, flag_q;

    // Offset decode and write strobes.
    assign hit_cnt    = (bus_addr == ADDR_W'(OFS_COUNT));
    assign hit_ts     = (bus_addr == ADDR_W'(OFS_TSTAMP));
    assign hit_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
    assign cnt_we     = bus_we && hit_cnt && (|bus_be);
    assign ctrl_we    = bus_we && hit_ctrl && bus_be[0];
    assign ctrl_wbyte = bus_wdata[7:0];

    assign en_q   = ctrl_q.en;
    assign per_q  = ctrl_q.per;
    assign rld_q  = ctrl_q.rld;
    assign flag_q = ctrl_q.tc;

    evt_tmr_tstamp #(.TS_W(TS_W)) u_ts (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_en),
        .ts_q  (ts_q)
    );

    evt_tmr_cdown #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cd (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en),
        .run      (en_q),
        .auto_rld (per_q && rld_q),
        .ld_we    (cnt_we),
        .ld_be    (bus_be),
        .ld_data  (bus_wdata),
        .cnt_q    (cnt_q),
        .tc_pulse (tc_pulse)
    );

    evt_tmr_csr u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (ctrl_we),
        .wr_byte  (ctrl_wbyte),
        .tc_pulse (tc_pulse),
        .ctrl_q   (ctrl_q)
    );

    // Read mux; unmapped offsets and unused control bits read as zero.
    always_comb begin
        bus_rdata = '0;
        if (hit_cnt)       bus_rdata = DATA_W'(cnt_q);
        else if (hit_ts)   bus_rdata = DATA_W'(ts_q);
        else if (hit_ctrl) bus_rdata = DATA_W'({flag_q, 4'b0000, rld_q, per_q, en_q});
    end

    assign irq = flag_q;
endmodule

// File: rtl/evt_tmr_chk.sv
// Temporal checks on the event timer, attached by bind. Observes the
// decoded write strobes and the counter and control state.
module evt_tmr_chk #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned TS_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             cnt_we,
    input logic             ctrl_we,
    input logic [7:0]       ctrl_wbyte,
    input logic [CNT_W-1:0] cnt_q,
    input logic [TS_W-1:0]  ts_q,
    input logic             en_q,
    input logic             per_q,
    input logic             rld_q,
    input logic             flag_q,
    input logic             irq
);
    p_ts_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> ts_q == $past(ts_q) + 1'b1);

    p_ts_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(ts_q));

    p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en && !cnt_we |=> $stable(cnt_q));

    p_cnt_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en_q && tick_en && cnt_q > 1 && !cnt_we |=> cnt_q == $past(cnt_q) - 1'b1);

    p_tc_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en_q && tick_en && cnt_q <= 1 |=> flag_q);

    p_oneshot_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en_q && tick_en && cnt_q <= 1 && !(per_q && rld_q) && !ctrl_we |=> !en_q);

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q && !(ctrl_we && ctrl_wbyte[7]) |=> flag_q);

    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(en_q && tick_en));
endmodule

bind evt_tmr_top evt_tmr_chk #(.CNT_W(CNT_W), .TS_W(TS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .cnt_we     (cnt_we),
    .ctrl_we    (ctrl_we),
    .ctrl_wbyte (ctrl_wbyte),
    .cnt_q      (cnt_q),
    .ts_q       (ts_q),
    .en_q       (en_q),
    .per_q      (per_q),
    .rld_q      (rld_q),
    .flag_q     (flag_q),
    .irq        (irq)
);

// File: tb/evt_tmr_top_tb_top.sv
// Bench: behavioural model compared on every clock, plus directed checks.
module evt_tmr_top_tb_top;
    localparam int TSW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    evt_tmr_top #(.TS_W(TSW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // Reference model state.
    logic [31:0] m_cnt, m_rel, m_ts;
    bit m_en, m_per, m_rl, m_flag, m_fire;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_rel = 0; m_ts = 0;
            m_en = 0; m_per = 0; m_rl = 0; m_flag = 0;
        end else begin
            m_fire = m_en && tick_en && (m_cnt < 2);
            if (tick_en) m_ts = (m_ts + 1) % (1 << TSW);
            if (bus_we && bus_addr == 8'h00 && bus_be != 0) begin
                for (int b = 0; b < 4; b++)
                    if (bus_be[b]) begin
                        m_cnt[b*8 +: 8] = bus_wdata[b*8 +: 8];
                        m_rel[b*8 +: 8] = bus_wdata[b*8 +: 8];
                    end
            end else if (m_en && tick_en) begin
                if (!m_fire) m_cnt = m_cnt - 1;
                else if (m_per && m_rl) m_cnt = m_rel;
                else m_cnt = 0;
            end
            if (bus_we && bus_addr == 8'h14 && bus_be[0]) begin
                if (bus_wdata[7]) m_flag = 0;
                m_en = bus_wdata[0]; m_per = bus_wdata[1]; m_rl = bus_wdata[2];
            end else if (m_fire && !(m_per && m_rl)) begin
                m_en = 0;
            end
            if (m_fire) m_flag = 1;
        end
    end

    function automatic logic [31:0] model_rd(logic [7:0] a);
        case (a)
            8'h00:   return m_cnt;
            8'h08:   return m_ts;
            8'h14:   return {24'd0, m_flag, 4'd0, m_rl, m_per, m_en};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison, between the clock edge and the input change.
    always begin
        @(posedge clk);
        #3;
        if (rst_n && !done) begin
            chk("R9 cycle irq", {31'd0, irq}, {31'd0, m_flag});
            chk("R4 cycle read", bus_rdata, model_rd(bus_addr));
        end
    end

    task automatic op(logic [7:0] a, logic we, logic [3:0] be, logic [31:0] d, logic t);
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_be = be; bus_wdata = d; tick_en = t;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] be = 4'hF, logic t = 0);
        op(a, 1'b1, be, d, t);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) op(8'h00, 1'b0, 4'h0, 32'h0, 1'b1);
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        op(a, 1'b0, 4'h0, 32'h0, 1'b0);
        #1 v = bus_rdata;
    endtask

    task automatic expect_rd(logic [7:0] a, logic [31:0] e, string tag);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, e);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v1, v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_rd(8'h00, 0, "R1 count");
        expect_rd(8'h08, 0, "R1 tstamp");
        expect_rd(8'h14, 0, "R1 ctrl");
        chk("R1 irq", {31'd0, irq}, 0);
        // R3 byte-enabled loads
        wr(8'h00, 32'h11223344);
        expect_rd(8'h00, 32'h11223344, "R3 word load");
        wr(8'h00, 32'h0000AA00, 4'b0010);
        expect_rd(8'h00, 32'h1122AA44, "R3 byte load");
        // R4 decrement only on ticks
        wr(8'h00, 5);
        wr(8'h14, 32'h81);
        expect_rd(8'h14, 32'h01, "R11 armed");
        op(8'h00, 0, 0, 0, 0); op(8'h00, 0, 0, 0, 0);
        expect_rd(8'h00, 5, "R4 hold without tick");
        ticks(2);
        expect_rd(8'h00, 3, "R4 two ticks");
        // R5 one-shot terminal count
        ticks(3);
        expect_rd(8'h00, 0, "R5 count at zero");
        expect_rd(8'h14, 32'h80, "R5 flag set enable cleared");
        chk("R9 irq high", {31'd0, irq}, 1);
        ticks(2);
        expect_rd(8'h00, 0, "R5 stays zero");
        // R7 write-one-to-clear
        wr(8'h14, 32'h00);
        expect_rd(8'h14, 32'h80, "R7 zero keeps flag");
        wr(8'h14, 32'h80);
        expect_rd(8'h14, 32'h00, "R7 one clears flag");
        chk("R9 irq low", {31'd0, irq}, 0);
        // R11 clear and arm while pending
        wr(8'h00, 1); wr(8'h14, 32'h81); ticks(1);
        expect_rd(8'h14, 32'h80, "R11 flag pending");
        wr(8'h00, 4); wr(8'h14, 32'h81);
        expect_rd(8'h14, 32'h01, "R11 cleared and armed");
        ticks(1);
        expect_rd(8'h00, 3, "R11 counts from load");
        // R7 stop
        wr(8'h14, 32'h80);
        ticks(2);
        expect_rd(8'h00, 3, "R7 stopped count holds");
        // R6 auto-reload
        wr(8'h00, 2); wr(8'h14, 32'h87); ticks(2);
        expect_rd(8'h00, 2, "R6 reloaded");
        expect_rd(8'h14, 32'h87, "R6 enable kept flag set");
        ticks(1);
        expect_rd(8'h00, 1, "R6 keeps counting");
        wr(8'h14, 32'h80);
        // R5 period without reload stays one-shot
        wr(8'h00, 1); wr(8'h14, 32'h83); ticks(1);
        expect_rd(8'h14, 32'h82, "R5 period only one-shot");
        wr(8'h14, 32'h80);
        // R8 terminal count and clearing write collide
        wr(8'h00, 1); wr(8'h14, 32'h81);
        wr(8'h14, 32'h80, 4'hF, 1'b1);
        expect_rd(8'h14, 32'h80, "R8 set wins over clear");
        chk("R8 irq", {31'd0, irq}, 1);
        wr(8'h14, 32'h80);
        // R10 unmapped offsets
        wr(8'h00, 9);
        wr(8'h04, 32'hFFFFFFFF); wr(8'h0C, 32'hFFFFFFFF); wr(8'h18, 32'hFFFFFFFF);
        expect_rd(8'h04, 0, "R10 read 0x04");
        expect_rd(8'h0C, 0, "R10 read 0x0C");
        expect_rd(8'h10, 0, "R10 read 0x10");
        expect_rd(8'h18, 0, "R10 read 0x18");
        expect_rd(8'h00, 9, "R10 count untouched");
        wr(8'h14, 32'hFFFFFF7F);
        expect_rd(8'h14, 32'h07, "R10 reserved bits zero");
        wr(8'h14, 32'h80);
        // R2 timestamp: ignores writes, wraps
        rd(8'h08, v1);
        wr(8'h08, 32'h55);
        expect_rd(8'h08, v1, "R2 write ignored");
        wr(8'h14, 32'h80, 4'hF, 1'b1);
        expect_rd(8'h08, (v1 + 1) & 32'hFF, "R2 ctrl write no effect");
        rd(8'h08, v2);
        ticks(300);
        expect_rd(8'h08, (v2 + 300) & 32'hFF, "R2 wrap");
        finish_run();
    end
endmodule